// File: doc/BRIEF.md
# Receive Byte Queue with Level and Idle Interrupts

This block is the receive half of a serial port's buffering. A shift register upstream assembles each character and presents it for one cycle with a valid strobe. The block stores up to sixteen bytes in arrival order. The CPU drains them through a read strobe, and each read returns the oldest byte on the next cycle. A CPU that services the port by interrupt does not need to poll, because two interrupt outputs tell it when to read. The first asserts once the queue holds at least a programmable number of bytes. The second asserts when a short tail of bytes has been left sitting with no traffic for four character times.

A byte that arrives while all sixteen entries are occupied is dropped, and a sticky overrun flag records the loss. The flag stays set until the CPU pulses a status-read strobe. The idle timer is a three-state machine: IDLE, RUN and FIRED. IDLE means the queue is empty. RUN means bytes are waiting and the timer counts baud ticks (sixteen per bit, ten bits per character). FIRED means the limit of 640 ticks has been reached. These are the transitions:

- IDLE to RUN on any access.
- RUN to RUN (with the counter cleared) on any access.
- RUN to FIRED when the tick that completes the limit arrives with no access.
- FIRED to RUN on any access.
- RUN or FIRED to IDLE when the queue is seen empty with no access.

An access is a strobe on either the valid input or the read input.

Top module: `rxq_top`

## Requirements
- R1: The queue holds 16 bytes and returns them in the order they arrived. A write is accepted when fewer than 16 bytes are stored, judged on the count before that cycle.
- R2: `trig_sel` selects the threshold: 0 for 1 byte, 1 for 4, 2 for 8 and 3 for 14. While `rx_irq_en` is 1, `data_irq` is 1 whenever the stored count is at or above the threshold.
- R3: `data_irq` drops in the same cycle that a read takes the count below the threshold. `data_irq` is 0 whenever `rx_irq_en` is 0.
- R4: A write strobe while 16 bytes are stored is discarded, and the stored bytes are kept. `overrun` reads 1 from the next cycle.
- R5: `overrun` stays at 1 until a cycle with `stat_rd` high and no new overrun. It reads 0 from the cycle after that.
- R6: With at least one byte stored and `rx_irq_en` high, `timeout_irq` rises right after the 640th baud tick that follows the last access. An access is a cycle with `rx_valid` or `rd_stb` high. It stays low before that tick.
- R7: A read or a new byte clears `timeout_irq` on the next cycle and restarts the 640-tick count.
- R8: The idle count advances only on cycles with `baud_tick` high. `timeout_irq` never asserts while the queue is empty.
- R9: A read strobe on an empty queue yields `rd_data` = 0 and leaves the queue unchanged. The next byte written is the next byte read.
- R10: `rd_data` takes the oldest byte on the clock edge where `rd_stb` is sampled high, and holds it until the next read.
- R11: After reset, `rd_data`, `data_irq`, `timeout_irq` and `overrun` are 0, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One pulse per sixteenth of a bit period |
| rx_valid | input | 1 | Assembled byte present this cycle |
| rx_byte | input | 8 | Assembled byte |
| rd_stb | input | 1 | CPU read of the queue |
| stat_rd | input | 1 | CPU status read; clears the overrun flag |
| rx_irq_en | input | 1 | Enables both interrupt outputs |
| trig_sel | input | 2 | Threshold code (1/4/8/14 bytes) |
| rd_data | output | 8 | Byte returned by the last read |
| data_irq | output | 1 | Fill level at or above threshold |
| timeout_irq | output | 1 | Bytes waiting with no access for four characters |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
The assertions assume that `rx_valid` and `rd_stb` are one-cycle strobes sampled on the rising edge. They also assume that `trig_sel` and `rx_irq_en` change only between transactions, so that any change in an interrupt output can be traced to a change in the fill count. The stimulus drives every input on the falling edge and holds strobes for exactly one cycle. It sweeps every threshold across every fill level from 0 to 16, with `baud_tick` held low so that the idle timer cannot interfere. It then raises the tick continuously, or holds it low on purpose, while it measures the 640-tick window exactly.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_RUN   = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        int unsigned r;
        unique case (sel)
            2'd0: r = 1;
            2'd1: r = 4;
            2'd2: r = 8;
            default: r = 14;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              stat_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              overrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, wr_ptr_nx, rd_ptr_nx;
    logic              full, empty, do_push, do_pop, lost;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign lost    = push_req && full;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_ptr_nx = wr_ptr + 1'b1;
            assign rd_ptr_nx = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_ptr_nx = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            assign rd_ptr_nx = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr_nx;
            if (do_pop)  rd_ptr <= rd_ptr_nx;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (pop_req) rd_data <= empty ? '0 : mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        overrun <= 1'b0;
        else if (lost)     overrun <= 1'b1;
        else if (stat_clr) overrun <= 1'b0;
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop_req) |=> (overrun && count == FULL_CNT));

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !stat_clr) |=> overrun);

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push_req) |=> (rd_data == '0 && count == '0));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int BITS_PER_CHAR = 10,
    parameter int IDLE_CHARS    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic touch,
    input  logic occupied,
    output logic fired
);
    localparam int LIMIT = TICKS_PER_BIT * BITS_PER_CHAR * IDLE_CHARS;
    localparam int TW    = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST_TICK = TW'(LIMIT - 1);

    to_state_e       state, state_nx;
    logic [TW-1:0]   tcnt, tcnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TO_IDLE;
            tcnt  <= '0;
        end else begin
            state <= state_nx;
            tcnt  <= tcnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        tcnt_nx  = '0;
        unique case (state)
            TO_IDLE: begin
                if (touch) state_nx = TO_RUN;
            end
            TO_RUN: begin
                if (touch) begin
                    state_nx = TO_RUN;
                end else if (!occupied) begin
                    state_nx = TO_IDLE;
                end else if (baud_tick) begin
                    if (tcnt == LAST_TICK) state_nx = TO_FIRED;
                    else                   tcnt_nx  = tcnt + 1'b1;
                end else begin
                    tcnt_nx = tcnt;
                end
            end
            TO_FIRED: begin
                if (touch)          state_nx = TO_RUN;
                else if (!occupied) state_nx = TO_IDLE;
            end
            default: state_nx = TO_IDLE;
        endcase
    end

    always_comb begin
        fired = (state == TO_FIRED);
    end

    // R7
    touch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !fired);

    // R8
    fired_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> occupied);

    // R8
    fire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fired) |-> $past(baud_tick));

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int BITS_PER_CHAR = 10,
    parameter int IDLE_CHARS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rd_stb,
    input  logic              stat_rd,
    input  logic              rx_irq_en,
    input  logic [1:0]        trig_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_irq,
    output logic              timeout_irq,
    output logic              overrun
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fill;
    logic [CW-1:0] thresh;
    logic          idle_fired;

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (rx_valid),
        .push_data (rx_byte),
        .pop_req   (rd_stb),
        .stat_clr  (stat_rd),
        .rd_data   (rd_data),
        .count     (fill),
        .overrun   (overrun)
    );

    rxq_timer #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .BITS_PER_CHAR (BITS_PER_CHAR),
        .IDLE_CHARS    (IDLE_CHARS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .touch     (rx_valid || rd_stb),
        .occupied  (fill != '0),
        .fired     (idle_fired)
    );

    always_comb begin
        thresh      = CW'(trig_bytes(trig_sel));
        data_irq    = rx_irq_en && (fill >= thresh);
        timeout_irq = rx_irq_en && idle_fired;
    end

    // R2
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(data_irq) && $stable(trig_sel) && $stable(rx_irq_en)) |-> $past(rx_valid));

endmodule

// File: tb/rxq_top_tb.sv
`timescale 1ns/1ps
module rxq_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rd_stb = 1'b0;
    logic       stat_rd = 1'b0;
    logic       rx_irq_en = 1'b0;
    logic [1:0] trig_sel = '0;
    logic [7:0] rd_data;
    logic       data_irq, timeout_irq, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rxq_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rd_stb(rd_stb), .stat_rd(stat_rd),
        .rx_irq_en(rx_irq_en), .trig_sel(trig_sel), .rd_data(rd_data),
        .data_irq(data_irq), .timeout_irq(timeout_irq), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int thr(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk) begin rx_valid = 1'b1; rx_byte = b; end
        @(negedge clk) rx_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(2);
        do_reset();
        // R11 reset state
        check("R11 rd_data", rd_data, 0);
        check("R11 data_irq", data_irq, 0);
        check("R11 timeout_irq", timeout_irq, 0);
        check("R11 overrun", overrun, 0);

        // R1 R2 R3 R10: every threshold against every fill level, ticks off
        for (int s = 0; s < 4; s++) begin
            do_reset();
            trig_sel = 2'(s);
            rx_irq_en = 1'b1;
            #1 check("R2 empty", data_irq, 0);
            for (int i = 0; i < 16; i++) begin
                push(8'((s * 16 + i) * 5 + 1));
                check("R2 fill", data_irq, (i + 1 >= thr(s)) ? 1 : 0);
            end
            rx_irq_en = 1'b0;
            #1 check("R3 disabled", data_irq, 0);
            rx_irq_en = 1'b1;
            for (int i = 0; i < 16; i++) begin
                pop();
                check("R10 R1 order", rd_data, (s * 16 + i) * 5 + 1 & 255);
                check("R3 drain", data_irq, (15 - i >= thr(s)) ? 1 : 0);
            end
            idle(3);
            check("R10 hold", rd_data, (s * 16 + 15) * 5 + 1 & 255);
        end

        // R4 R5 R9 overrun and empty reads
        do_reset();
        trig_sel = 2'd3;
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
        check("R4 no overrun yet", overrun, 0);
        push(8'hEE);
        check("R4 overrun set", overrun, 1);
        idle(5);
        check("R5 sticky", overrun, 1);
        @(negedge clk) stat_rd = 1'b1;
        @(negedge clk) stat_rd = 1'b0;
        check("R5 cleared", overrun, 0);
        for (int i = 0; i < 16; i++) begin
            pop();
            check("R4 contents kept", rd_data, (i * 7 + 3) & 255);
        end
        pop();
        check("R9 empty read", rd_data, 0);
        pop();
        check("R9 empty read again", rd_data, 0);
        check("R9 no irq", data_irq, 0);
        push(8'h5A);
        check("R9 fill after empty read", data_irq, 0);
        trig_sel = 2'd0;
        #1 check("R9 one stored", data_irq, 1);
        pop();
        check("R9 pointer intact", rd_data, 8'h5A);

        // R6 R7 idle timeout, tick every cycle
        do_reset();
        rx_irq_en = 1'b1;
        baud_tick = 1'b1;
        idle(700);
        check("R8 empty no timeout", timeout_irq, 0);
        push(8'h11);
        push(8'h22);
        idle(639);
        check("R6 before limit", timeout_irq, 0);
        idle(1);
        check("R6 at limit", timeout_irq, 1);
        rx_irq_en = 1'b0;
        #1 check("R6 gated", timeout_irq, 0);
        rx_irq_en = 1'b1;
        pop();
        check("R7 read clears", timeout_irq, 0);
        check("R7 read value", rd_data, 8'h11);
        idle(639);
        check("R7 restart low", timeout_irq, 0);
        idle(1);
        check("R7 restart high", timeout_irq, 1);
        push(8'h33);
        check("R7 write clears", timeout_irq, 0);
        idle(300);
        pop();
        pop();
        idle(800);
        check("R8 drained no timeout", timeout_irq, 0);

        // R8 ticks gate the count
        baud_tick = 1'b0;
        push(8'h44);
        idle(1000);
        check("R8 no ticks", timeout_irq, 0);
        baud_tick = 1'b1;
        idle(639);
        check("R8 ticks resume low", timeout_irq, 0);
        idle(1);
        check("R8 ticks resume high", timeout_irq, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule